// File: doc/BRIEF.md
# Multiplexed Display Scan Timing Generator

This block produces the common-line scan timing for a time-multiplexed LED or LCD panel. A clock-enable tick arrives from one of two display clock sources, a slow 32.768 kHz source or a fast 128 kHz source, and a source-select input tells the block which one is running. A small configuration port sets the number of commons scanned per frame, the divider applied to the fast source, a pin-release switch and a hold control.

Each frame is split into equal common slots. When the frame does not divide evenly, the last slot is longer. The block drives a one-hot common select, the binary index of the active common and a one-cycle pulse at each frame start. When the pin-release switch is set, every display pin is handed over to general I/O and the common outputs go quiet. During that time the scan either keeps running or freezes in place, depending on the hold control. Changes to the common count, the divider and the source take effect only at a frame boundary.

Top module: `disp_scan_gen`

## Requirements
- R1: Reset clears the common-count code, the divider code, the pin-release switch and the hold control, and selects the fast source. After reset, `com_idx_o`=0, `com_o`=1, `frame_start_o`=0 and `pins_io_o`=0, so the block scans 4 commons with divide-by-4.
- R2: The 3-bit `cfg_duty_i` code sets the number of commons N as follows: 3'b000→4, 3'b001→8, 3'b010→3, 3'b011→5, 3'b100→6, 3'b101→7. Codes 3'b110 and 3'b111 give 4.
- R3: `com_idx_o` counts 0, 1, …, N−1 and then wraps to 0. It changes only in the cycle after an accepted tick. While the display is enabled, `com_o` has exactly bit `com_idx_o` set.
- R4: With the slow source (`src_slow_i`=1), a frame lasts 512 ticks whatever the value of `cfg_psc_i`.
- R5: With the fast source, the 2-bit `cfg_psc_i` code sets a divider d: 2'b00→4, 2'b01→3, 2'b10→2, 2'b11→1. A frame lasts 500 divided steps, which is 500·d ticks.
- R6: Slot k (k<N−1) lasts floor(L/N) steps. The last slot lasts L−(N−1)·floor(L/N) steps. L is 512 on the slow source and 500 on the fast source.
- R7: `frame_start_o` is high for exactly one cycle, in the cycle in which `com_idx_o` returns to 0 at a frame wrap.
- R8: While `cfg_io_i` is latched at 1, `pins_io_o`=1 and `com_o` is all zero. When it is latched at 0, `pins_io_o`=0.
- R9: While the pins are released and hold is 0, the scan counters keep advancing.
- R10: While the pins are released and hold is 1, the scan freezes and no frame pulse occurs. When the pins return to the display, scanning resumes from the kept index.
- R11: A write of the common count or the divider, and a change of `src_slow_i`, take effect at the next frame wrap. The frame in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock-enable tick from the display clock source |
| src_slow_i | input | 1 | 1: slow 32.768 kHz source, 0: fast 128 kHz source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_duty_i | input | 3 | Common-count code |
| cfg_psc_i | input | 2 | Fast-source divider code |
| cfg_io_i | input | 1 | Pin release to general I/O |
| cfg_hold_i | input | 1 | Freeze the scan while the pins are released |
| com_o | output | 8 | One-hot common select |
| com_idx_o | output | 3 | Index of the active common |
| frame_start_o | output | 1 | One-cycle pulse at frame start |
| pins_io_o | output | 1 | Display pins serve as general I/O |

## Verification
A wrong slot or divider count shows up at the ports within one slot as a late or early change of `com_idx_o`. A wrong common-count decode shows up within one frame as a missing or extra index before the wrap. A config that is applied too early shortens the frame in progress, and that is visible at the next `frame_start_o`. A freeze fault shows at once as index motion during the hold window, or as a different index after the pins return. The reference model in the bench flags any of these in the first cycle in which the outputs differ.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;

  typedef struct packed {
    logic [2:0] duty;
    logic [1:0] psc;
    logic       slow;
  } frame_cfg_t;

  function automatic int unsigned duty_ncom(logic [2:0] code);
    case (code)
      3'b001:  return 8;
      3'b010:  return 3;
      3'b011:  return 5;
      3'b100:  return 6;
      3'b101:  return 7;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/disp_psc.sv
module disp_psc (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       slow_i,
  input  logic [1:0] psc_i,
  output logic       step_o
);
  logic [1:0] cnt_q;
  logic [2:0] div_last;
  logic       adv;

  assign div_last = 3'd3 - {1'b0, psc_i};
  assign adv      = tick_i && run_i;
  assign step_o   = adv && (slow_i || ({1'b0, cnt_q} == div_last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (adv && !slow_i) cnt_q <= ({1'b0, cnt_q} == div_last) ? 2'd0 : cnt_q + 2'd1;
  end
endmodule

// File: rtl/disp_slot_seq.sv
module disp_slot_seq #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned NUM_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [NUM_W-1:0] ncom_i,
  input  logic [CNT_W-1:0] flen_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] slot_q, base_len, last_len, cur_len;
  logic [IDX_W-1:0] idx_q;
  logic             is_last, slot_end;

  // remainder of an uneven split goes to the last slot
  assign base_len = CNT_W'(flen_i / CNT_W'(ncom_i));
  assign last_len = flen_i - CNT_W'(base_len * CNT_W'(ncom_i - NUM_W'(1)));
  assign is_last  = (NUM_W'(idx_q) == ncom_i - NUM_W'(1));
  assign cur_len  = is_last ? last_len : base_len;
  assign slot_end = (slot_q == cur_len - CNT_W'(1));
  assign wrap_o   = step_i && slot_end && is_last;
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      idx_q  <= '0;
    end else if (step_i) begin
      if (slot_end) begin
        slot_q <= '0;
        idx_q  <= is_last ? '0 : idx_q + IDX_W'(1);
      end else begin
        slot_q <= slot_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/disp_com_dec.sv
module disp_com_dec #(
  parameter int unsigned MAX_COM = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               en_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [MAX_COM-1:0] com_o
);
  for (genvar i = 0; i < MAX_COM; i++) begin : g_com
    assign com_o[i] = en_i && (idx_i == IDX_W'(i));
  end
endmodule

// File: rtl/disp_scan_gen.sv
module disp_scan_gen
  import disp_scan_pkg::*;
#(
  parameter int unsigned MAX_COM  = 8,
  parameter int unsigned SLOW_LEN = 512,
  parameter int unsigned FAST_LEN = 500,
  localparam int unsigned IDX_W   = $clog2(MAX_COM),
  localparam int unsigned NUM_W   = $clog2(MAX_COM + 1),
  localparam int unsigned MAX_LEN = (SLOW_LEN > FAST_LEN) ? SLOW_LEN : FAST_LEN,
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               src_slow_i,
  input  logic               cfg_we_i,
  input  logic [2:0]         cfg_duty_i,
  input  logic [1:0]         cfg_psc_i,
  input  logic               cfg_io_i,
  input  logic               cfg_hold_i,
  output logic [MAX_COM-1:0] com_o,
  output logic [IDX_W-1:0]   com_idx_o,
  output logic               frame_start_o,
  output logic               pins_io_o
);
  frame_cfg_t       shadow_q, act_q;
  logic             io_q, hold_q, fs_q;
  logic             run, step, wrap;
  logic [NUM_W-1:0] n_act;
  logic [CNT_W-1:0] flen;

  assign run   = !(io_q && hold_q);
  assign n_act = NUM_W'(duty_ncom(act_q.duty));
  assign flen  = act_q.slow ? CNT_W'(SLOW_LEN) : CNT_W'(FAST_LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      act_q    <= '0;
      io_q     <= 1'b0;
      hold_q   <= 1'b0;
      fs_q     <= 1'b0;
    end else begin
      fs_q <= wrap;
      if (wrap) act_q <= '{duty: shadow_q.duty, psc: shadow_q.psc, slow: src_slow_i};
      if (cfg_we_i) begin
        shadow_q.duty <= cfg_duty_i;
        shadow_q.psc  <= cfg_psc_i;
        io_q          <= cfg_io_i;
        hold_q        <= cfg_hold_i;
      end
    end
  end

  disp_psc u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (run),
    .slow_i (act_q.slow),
    .psc_i  (act_q.psc),
    .step_o (step)
  );

  disp_slot_seq #(.CNT_W(CNT_W), .IDX_W(IDX_W), .NUM_W(NUM_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .ncom_i (n_act),
    .flen_i (flen),
    .idx_o  (com_idx_o),
    .wrap_o (wrap)
  );

  disp_com_dec #(.MAX_COM(MAX_COM), .IDX_W(IDX_W)) u_dec (
    .en_i  (!io_q),
    .idx_i (com_idx_o),
    .com_o (com_o)
  );

  assign frame_start_o = fs_q;
  assign pins_io_o     = io_q;
endmodule

// File: rtl/disp_scan_chk.sv
module disp_scan_chk #(
  parameter int unsigned MAX_COM = 8,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned NUM_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic [MAX_COM-1:0] com_o,
  input logic [IDX_W-1:0]   com_idx_o,
  input logic               frame_start_o,
  input logic               pins_io_o,
  input logic               hold_q,
  input logic [NUM_W-1:0]   n_act
);
  // R3
  com_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pins_io_o |-> (com_o == (MAX_COM'(1) << com_idx_o)));
  // R3
  idx_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(com_idx_o));
  // R2
  idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    NUM_W'(com_idx_o) < n_act);
  // R7
  fs_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (com_idx_o == '0));
  // R7
  fs_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
  // R8
  io_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_io_o |-> (com_o == '0));
  // R10
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_io_o && hold_q) |=> $stable(com_idx_o));
endmodule

bind disp_scan_gen disp_scan_chk #(.MAX_COM(MAX_COM), .IDX_W(IDX_W), .NUM_W(NUM_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .com_o         (com_o),
  .com_idx_o     (com_idx_o),
  .frame_start_o (frame_start_o),
  .pins_io_o     (pins_io_o),
  .hold_q        (hold_q),
  .n_act         (n_act)
);

// File: tb/tb_disp_scan_gen.sv
module tb_disp_scan_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       src_slow_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [2:0] cfg_duty_i = '0;
  logic [1:0] cfg_psc_i = '0;
  logic       cfg_io_i = 1'b0;
  logic       cfg_hold_i = 1'b0;
  logic [7:0] com_o;
  logic [2:0] com_idx_o;
  logic       frame_start_o;
  logic       pins_io_o;

  int n_chk = 0;
  int n_fail = 0;
  int tick_mode = 0;
  bit model_on = 0;
  bit done = 0;

  disp_scan_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .src_slow_i(src_slow_i),
    .cfg_we_i(cfg_we_i), .cfg_duty_i(cfg_duty_i), .cfg_psc_i(cfg_psc_i),
    .cfg_io_i(cfg_io_i), .cfg_hold_i(cfg_hold_i), .com_o(com_o),
    .com_idx_o(com_idx_o), .frame_start_o(frame_start_o), .pins_io_o(pins_io_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic int ncom(int code);
    case (code)
      1: return 8;
      2: return 3;
      3: return 5;
      4: return 6;
      5: return 7;
      default: return 4;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model
  int m_idx, m_slot, m_psc, m_fs, a_n, a_div, a_slow, p_duty, p_psc, m_io, m_hold;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_idx = 0; m_slot = 0; m_psc = 0; m_fs = 0; a_n = 4; a_div = 4; a_slow = 0;
      p_duty = 0; p_psc = 0; m_io = 0; m_hold = 0;
    end else begin
      m_fs = 0;
      if (tick_i && !(m_io != 0 && m_hold != 0)) begin
        bit stp;
        stp = 0;
        if (a_slow != 0) stp = 1;
        else if (m_psc == a_div - 1) begin m_psc = 0; stp = 1; end
        else m_psc++;
        if (stp) begin
          int flen, base, cur;
          flen = (a_slow != 0) ? 512 : 500;
          base = flen / a_n;
          cur  = (m_idx == a_n - 1) ? flen - base * (a_n - 1) : base;
          if (m_slot == cur - 1) begin
            m_slot = 0;
            if (m_idx == a_n - 1) begin
              m_idx = 0; m_fs = 1;
              a_n = ncom(p_duty); a_div = 4 - p_psc; a_slow = int'(src_slow_i);
            end else m_idx++;
          end else m_slot++;
        end
      end
      if (cfg_we_i) begin
        p_duty = int'(cfg_duty_i); p_psc = int'(cfg_psc_i);
        m_io = int'(cfg_io_i); m_hold = int'(cfg_hold_i);
      end
    end
  end

  // R3: per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (model_on && !done) begin
      int ec;
      ec = (m_io != 0) ? 0 : (1 << m_idx);
      chk(int'(com_idx_o) == m_idx, "R3 idx", int'(com_idx_o), m_idx);
      chk(int'(com_o) == ec, "R3 com", int'(com_o), ec);
      chk(int'(frame_start_o) == m_fs, "R7 frame_start", int'(frame_start_o), m_fs);
      chk(int'(pins_io_o) == m_io, "R8 pins_io", int'(pins_io_o), m_io);
    end
  end

  // tick source
  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk_i);
      c++;
      tick_i = (tick_mode == 0) ? 1'b1 : (tick_mode == 1 ? (c % 3 == 0) : 1'b0);
    end
  end

  task automatic wr(int duty, int psc, bit io, bit hold);
    cfg_duty_i = 3'(duty); cfg_psc_i = 2'(psc); cfg_io_i = io; cfg_hold_i = hold;
    cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic wait_fs();
    do @(negedge clk_i); while (!frame_start_o);
  endtask

  // measures the frame starting at the next pulse
  task automatic meas(output int len, output int nseen, output int first, output int last);
    int per[8];
    for (int i = 0; i < 8; i++) per[i] = 0;
    wait_fs();
    len = 0;
    do begin
      per[com_idx_o]++;
      len++;
      @(negedge clk_i);
    end while (!frame_start_o);
    nseen = 0;
    for (int i = 0; i < 8; i++) if (per[i] != 0) nseen++;
    first = per[0];
    last = (nseen > 0) ? per[nseen - 1] : 0;
  endtask

  initial begin
    int len, ns, f, l, k, id0;
    bit seen;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(com_idx_o == 0, "R1 idx", int'(com_idx_o), 0);
    chk(com_o == 8'h01, "R1 com", int'(com_o), 1);
    chk(frame_start_o == 0, "R1 frame_start", int'(frame_start_o), 0);
    chk(pins_io_o == 0, "R1 pins_io", int'(pins_io_o), 0);
    model_on = 1;

    meas(len, ns, f, l);
    chk(len == 2000, "R1 R5 frame /4", len, 2000);
    chk(ns == 4, "R1 R2 commons", ns, 4);
    chk(f == 500, "R6 slot", f, 500);

    // R11: write mid-frame; current frame keeps old length
    wait_fs();
    k = 0;
    repeat (10) begin @(negedge clk_i); k++; end
    wr(2, 3, 0, 0);
    k++;
    while (!frame_start_o) begin @(negedge clk_i); k++; end
    chk(k == 2000, "R11 frame in progress", k, 2000);
    meas(len, ns, f, l);
    chk(len == 500, "R5 frame /1", len, 500);
    chk(ns == 3, "R2 code 010", ns, 3);
    chk(f == 166 && l == 168, "R6 uneven split", f * 1000 + l, 166168);

    wr(4, 3, 0, 0);
    meas(len, ns, f, l);
    meas(len, ns, f, l);
    chk(ns == 6, "R2 code 100", ns, 6);
    chk(f == 83 && l == 85, "R6 six slots", f * 1000 + l, 83085);

    wr(1, 2, 0, 0);
    meas(len, ns, f, l);
    meas(len, ns, f, l);
    chk(len == 1000, "R5 frame /2", len, 1000);
    chk(ns == 8, "R2 code 001", ns, 8);
    chk(f == 124 && l == 132, "R6 eight slots", f * 1000 + l, 124132);

    wr(6, 1, 0, 0);
    meas(len, ns, f, l);
    meas(len, ns, f, l);
    chk(len == 1500, "R5 frame /3", len, 1500);
    chk(ns == 4, "R2 code 110", ns, 4);

    wr(3, 0, 0, 0);
    meas(len, ns, f, l);
    meas(len, ns, f, l);
    chk(ns == 5, "R2 code 011", ns, 5);
    wr(5, 0, 0, 0);
    meas(len, ns, f, l);
    meas(len, ns, f, l);
    chk(ns == 7, "R2 code 101", ns, 7);

    // R4: slow source, divider ignored
    wr(7, 0, 0, 0);
    src_slow_i = 1'b1;
    meas(len, ns, f, l);
    meas(len, ns, f, l);
    chk(len == 512, "R4 slow psc 00", len, 512);
    chk(ns == 4, "R2 code 111", ns, 4);
    wr(0, 3, 0, 0);
    meas(len, ns, f, l);
    meas(len, ns, f, l);
    chk(len == 512, "R4 slow psc 11", len, 512);
    tick_mode = 1;
    meas(len, ns, f, l);
    meas(len, ns, f, l);
    chk(len == 1536, "R4 sparse ticks", len, 1536);
    tick_mode = 0;

    // R8/R9/R10: pin release
    src_slow_i = 1'b0;
    wr(2, 3, 0, 0);
    meas(len, ns, f, l);
    wr(2, 3, 1, 0);
    chk(pins_io_o == 1, "R8 pins_io", int'(pins_io_o), 1);
    chk(com_o == 0, "R8 com quiet", int'(com_o), 0);
    id0 = int'(com_idx_o);
    repeat (200) @(negedge clk_i);
    chk(int'(com_idx_o) != id0, "R9 keeps running", int'(com_idx_o), id0);
    wr(2, 3, 1, 1);
    id0 = int'(com_idx_o);
    seen = 0;
    repeat (3000) begin
      @(negedge clk_i);
      if (frame_start_o) seen = 1;
    end
    chk(int'(com_idx_o) == id0, "R10 frozen idx", int'(com_idx_o), id0);
    chk(!seen, "R10 no frame pulse", int'(seen), 0);
    wr(2, 3, 0, 1);
    chk(int'(com_idx_o) == id0, "R10 resume idx", int'(com_idx_o), id0);
    chk(pins_io_o == 0, "R8 pins back", int'(pins_io_o), 0);
    chk(int'(com_o) == (1 << id0), "R10 com resumes", int'(com_o), 1 << id0);
    meas(len, ns, f, l);
    chk(len == 500, "R10 scan resumed", len, 500);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    done = 1;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule